// File: doc/BRIEF.md
# Bitmap Pixel Serializer and Palette Colour Path

This block sits at the end of a video pipeline. It takes 24-bit words from bitmap memory and releases their six 4-bit pixels one at a time, the most significant nibble first, each time the pixel enable is high. A bitmap pixel of zero is transparent, so the pixel from the tile layer shows through in its place. The chosen pixel is joined with the 6-bit colour bank of its own layer to form a 10-bit index into a shared 1024-entry palette of 16-bit words.

Each palette word holds red, green, blue and intensity, 4 bits each. The three colours are scaled by the intensity and leave the block two clocks after the pixel was sampled. Blanking and idle cycles force the colour outputs to zero. The palette and both bank registers are written from a processor-side write port. Fetch timing and sync generation belong to neighbouring blocks.

Top module: `bpp_color_path`

## Requirements
- R1: On an edge where word_valid_i is high, the pixel taken is word_i[23:20]. Each later edge with pix_en_i high and word_valid_i low takes the next lower nibble: [19:16], [15:12], [11:8], [7:4], [3:0].
- R2: When word_valid_i is high and pix_en_i is low, the word is stored and no nibble is used up. An edge with pix_en_i low and word_valid_i low leaves the position unchanged. Once all six nibbles are used, the bitmap pixel reads as zero until the next load. A load restarts at bits [23:20] even in the middle of a word.
- R3: A nonzero bitmap pixel takes priority. A zero bitmap pixel selects tile_pix_i, which is sampled on the same edge.
- R4: The palette index is {bank, pixel}, with the bank in bits [9:4]. The bitmap bank goes with a bitmap pixel and the tile bank goes with a tile pixel.
- R5: An edge with fg_bank_we_i high loads bank_wdata_i into the bitmap bank, and bg_bank_we_i does the same for the tile bank. The new value applies to pixels sampled on later edges.
- R6: An edge with pal_we_i high writes pal_wdata_i to entry pal_waddr_i. The entry fields are red [15:12], green [11:8], blue [7:4] and intensity [3:0]. The write applies to pixels sampled on that edge or later.
- R7: Each colour output is floor(colour * (intensity + 1) / 16).
- R8: A pixel sampled at edge N appears on the outputs after edge N+1, with valid_o high. valid_o is high only for such pixels, and pixels leave in the order they were sampled.
- R9: If blank_i is high on the sampling edge, that pixel's red_o, grn_o and blu_o are 0, and valid_o is still high.
- R10: While valid_o is low, red_o, grn_o and blu_o are 0.
- R11: Reset clears valid_o, the colour outputs, both bank registers and the serializer, which then reads as all-transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | Load word_i into the serializer |
| word_i | input | 24 | Six packed 4-bit bitmap pixels |
| pix_en_i | input | 1 | Emit one pixel on this edge |
| tile_pix_i | input | 4 | Tile layer pixel for this position |
| blank_i | input | 1 | Force this pixel to black |
| fg_bank_we_i | input | 1 | Write the bitmap bank register |
| bg_bank_we_i | input | 1 | Write the tile bank register |
| bank_wdata_i | input | 6 | Bank register write data |
| pal_we_i | input | 1 | Palette write strobe |
| pal_waddr_i | input | 10 | Palette write address |
| pal_wdata_i | input | 16 | Palette write data (RGBI) |
| valid_o | output | 1 | Output pixel valid |
| red_o | output | 4 | Scaled red |
| grn_o | output | 4 | Scaled green |
| blu_o | output | 4 | Scaled blue |

## Verification
The risky state is the shift register and its position. A slip there makes the wrong nibble, or a stale nonzero nibble after the word is used up, reach the outputs two clocks after the bad edge. It shows as a colour from the wrong palette entry or as bitmap colour where tile colour should appear. A bank register that is wrong, or that updates on the wrong edge, shifts every following pixel of its layer to another group of 16 entries. The scoreboard catches this on the first pixel after the change. Pipeline flags that drift show up as valid_o pulses with no matching expected pixel, or as colour on idle cycles.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
  // Channel slot inside a palette word, lowest slot at bit 0
  localparam int unsigned CH_INT = 0;
  localparam int unsigned CH_BLU = 1;
  localparam int unsigned CH_GRN = 2;
  localparam int unsigned CH_RED = 3;
  localparam int unsigned N_SLOT = 4;
endpackage

// File: rtl/bpp_serializer.sv
module bpp_serializer #(
  parameter int unsigned PIX_W        = 4,
  parameter int unsigned PIX_PER_WORD = 6,
  localparam int unsigned WORD_W      = PIX_W * PIX_PER_WORD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              step_i,
  output logic [PIX_W-1:0]  pix_o
);
  logic [WORD_W-1:0] sr_q, sr_d, src;

  assign src   = load_i ? word_i : sr_q;
  assign pix_o = src[WORD_W-1 -: PIX_W];

  always_comb begin
    sr_d = sr_q;
    if (step_i)      sr_d = src << PIX_W;   // zeros fill in: transparent once used up
    else if (load_i) sr_d = word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
endmodule

// File: rtl/bpp_layer_mux.sv
module bpp_layer_mux #(
  parameter int unsigned PIX_W  = 4,
  parameter int unsigned BANK_W = 6,
  localparam int unsigned IDX_W = PIX_W + BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fg_we_i,
  input  logic              bg_we_i,
  input  logic [BANK_W-1:0] bank_wdata_i,
  input  logic [PIX_W-1:0]  fg_pix_i,
  input  logic [PIX_W-1:0]  bg_pix_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic [BANK_W-1:0] fg_bank_q, bg_bank_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      fg_bank_q <= '0;
      bg_bank_q <= '0;
    end else begin
      if (fg_we_i) fg_bank_q <= bank_wdata_i;
      if (bg_we_i) bg_bank_q <= bank_wdata_i;
    end

  assign idx_o = (fg_pix_i != '0) ? {fg_bank_q, fg_pix_i} : {bg_bank_q, bg_pix_i};
endmodule

// File: rtl/bpp_palette_ram.sv
module bpp_palette_ram #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/bpp_scaler.sv
module bpp_scaler
  import bpp_pkg::*;
#(
  parameter int unsigned COL_W   = 4,
  localparam int unsigned ENT_W  = COL_W * N_SLOT,
  localparam int unsigned PROD_W = 2 * COL_W + 1
) (
  input  logic [ENT_W-1:0]   entry_i,
  input  logic               kill_i,
  output logic [3*COL_W-1:0] rgb_o
);
  logic [COL_W:0] gain;
  assign gain = {1'b0, entry_i[CH_INT*COL_W +: COL_W]} + 1'b1;

  for (genvar k = CH_BLU; k <= CH_RED; k++) begin : g_ch
    logic [PROD_W-1:0] prod;
    assign prod = PROD_W'(entry_i[k*COL_W +: COL_W]) * PROD_W'(gain);
    assign rgb_o[(k-1)*COL_W +: COL_W] = kill_i ? '0 : prod[COL_W +: COL_W];
  end
endmodule

// File: rtl/bpp_color_path.sv
module bpp_color_path
  import bpp_pkg::*;
#(
  parameter int unsigned PIX_W        = 4,
  parameter int unsigned PIX_PER_WORD = 6,
  parameter int unsigned BANK_W       = 6,
  parameter int unsigned COL_W        = 4,
  localparam int unsigned WORD_W      = PIX_W * PIX_PER_WORD,
  localparam int unsigned IDX_W       = PIX_W + BANK_W,
  localparam int unsigned ENT_W       = COL_W * N_SLOT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              pix_en_i,
  input  logic [PIX_W-1:0]  tile_pix_i,
  input  logic              blank_i,
  input  logic              fg_bank_we_i,
  input  logic              bg_bank_we_i,
  input  logic [BANK_W-1:0] bank_wdata_i,
  input  logic              pal_we_i,
  input  logic [IDX_W-1:0]  pal_waddr_i,
  input  logic [ENT_W-1:0]  pal_wdata_i,
  output logic              valid_o,
  output logic [COL_W-1:0]  red_o,
  output logic [COL_W-1:0]  grn_o,
  output logic [COL_W-1:0]  blu_o
);
  logic [PIX_W-1:0]   bmp_pix;
  logic [IDX_W-1:0]   idx_d, idx_q;
  logic [1:0]         vld_q, blk_q;
  logic [ENT_W-1:0]   entry;
  logic [3*COL_W-1:0] rgb;

  bpp_serializer #(.PIX_W(PIX_W), .PIX_PER_WORD(PIX_PER_WORD)) u_ser (
    .clk_i, .rst_ni,
    .load_i (word_valid_i),
    .word_i (word_i),
    .step_i (pix_en_i),
    .pix_o  (bmp_pix)
  );

  bpp_layer_mux #(.PIX_W(PIX_W), .BANK_W(BANK_W)) u_mux (
    .clk_i, .rst_ni,
    .fg_we_i      (fg_bank_we_i),
    .bg_we_i      (bg_bank_we_i),
    .bank_wdata_i (bank_wdata_i),
    .fg_pix_i     (bmp_pix),
    .bg_pix_i     (tile_pix_i),
    .idx_o        (idx_d)
  );

  // stage 1: index; stage 2: palette read
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      idx_q <= '0;
      vld_q <= '0;
      blk_q <= '0;
    end else begin
      idx_q <= idx_d;
      vld_q <= {vld_q[0], pix_en_i};
      blk_q <= {blk_q[0], blank_i};
    end

  bpp_palette_ram #(.IDX_W(IDX_W), .DATA_W(ENT_W)) u_pal (
    .clk_i,
    .we_i    (pal_we_i),
    .waddr_i (pal_waddr_i),
    .wdata_i (pal_wdata_i),
    .raddr_i (idx_q),
    .rdata_o (entry)
  );

  bpp_scaler #(.COL_W(COL_W)) u_scl (
    .entry_i (entry),
    .kill_i  (!vld_q[1] || blk_q[1]),
    .rgb_o   (rgb)
  );

  assign valid_o = vld_q[1];
  assign red_o   = rgb[2*COL_W +: COL_W];
  assign grn_o   = rgb[COL_W +: COL_W];
  assign blu_o   = rgb[0 +: COL_W];
endmodule

// File: rtl/bpp_color_path_chk.sv
module bpp_color_path_chk #(
  parameter int unsigned PIX_W  = 4,
  parameter int unsigned WORD_W = 24,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned COL_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              word_valid_i,
  input logic [WORD_W-1:0] word_i,
  input logic              pix_en_i,
  input logic [PIX_W-1:0]  tile_pix_i,
  input logic              blank_i,
  input logic              valid_o,
  input logic [COL_W-1:0]  red_o,
  input logic [COL_W-1:0]  grn_o,
  input logic [COL_W-1:0]  blu_o,
  input logic [IDX_W-1:0]  idx_q
);
  logic [1:0] cyc;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;

  p_dark_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (red_o == '0 && grn_o == '0 && blu_o == '0));

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2) |-> (valid_o == $past(pix_en_i, 2)));

  p_blank_dark_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && $past(blank_i, 2)) |-> (red_o == '0 && grn_o == '0 && blu_o == '0));

  p_first_nibble_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd1 && $past(word_valid_i) && $past(word_i[WORD_W-1 -: PIX_W]) != '0)
      |-> (idx_q[PIX_W-1:0] == $past(word_i[WORD_W-1 -: PIX_W])));

  p_tile_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd1 && $past(word_valid_i) && $past(word_i[WORD_W-1 -: PIX_W]) == '0)
      |-> (idx_q[PIX_W-1:0] == $past(tile_pix_i)));
endmodule

bind bpp_color_path bpp_color_path_chk #(
  .PIX_W(PIX_W), .WORD_W(WORD_W), .IDX_W(IDX_W), .COL_W(COL_W)
) u_chk (
  .clk_i, .rst_ni, .word_valid_i, .word_i, .pix_en_i, .tile_pix_i, .blank_i,
  .valid_o, .red_o, .grn_o, .blu_o, .idx_q
);

// File: tb/bpp_color_path_tb.sv
`timescale 1ns/1ps
module bpp_color_path_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [23:0] word_i = '0;
  logic        pix_en_i = 1'b0;
  logic [3:0]  tile_pix_i = '0;
  logic        blank_i = 1'b0;
  logic        fg_bank_we_i = 1'b0;
  logic        bg_bank_we_i = 1'b0;
  logic [5:0]  bank_wdata_i = '0;
  logic        pal_we_i = 1'b0;
  logic [9:0]  pal_waddr_i = '0;
  logic [15:0] pal_wdata_i = '0;
  logic        valid_o;
  logic [3:0]  red_o, grn_o, blu_o;

  always #2.5 clk_i = ~clk_i;

  bpp_color_path dut_i (.*);

  typedef struct { logic [11:0] rgb; string tag; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] m_pal [1024];
  logic [23:0] m_sr = '0;
  logic [5:0]  m_fg = '0, m_bg = '0;

  function automatic logic [3:0] scl(logic [3:0] c, logic [3:0] i);
    logic [8:0] p = 9'(c) * (9'(i) + 9'd1);
    return p[7:4];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    word_valid_i = 0; pix_en_i = 0; blank_i = 0; tile_pix_i = '0;
    fg_bank_we_i = 0; bg_bank_we_i = 0; pal_we_i = 0;
  endtask

  // one cycle of pixel traffic; models the expected result
  task automatic cyc(bit wv, logic [23:0] w, bit pe, logic [3:0] tile, bit blk, string tag);
    logic [23:0] src;
    logic [3:0]  p;
    logic [9:0]  idx;
    logic [15:0] e;
    exp_t x;
    @(negedge clk_i);
    idle_inputs();
    word_valid_i = wv; word_i = w; pix_en_i = pe; tile_pix_i = tile; blank_i = blk;
    src = wv ? w : m_sr;
    if (pe) begin
      p   = src[23:20];
      idx = (p != 0) ? {m_fg, p} : {m_bg, tile};
      e   = m_pal[idx];
      x.rgb = blk ? 12'h000 : {scl(e[15:12], e[3:0]), scl(e[11:8], e[3:0]), scl(e[7:4], e[3:0])};
      x.tag = tag;
      exp_q.push_back(x);
      m_sr = src << 4;
    end else if (wv) m_sr = w;
  endtask

  task automatic pal_wr(logic [9:0] a, logic [15:0] d);
    @(negedge clk_i);
    idle_inputs();
    pal_we_i = 1; pal_waddr_i = a; pal_wdata_i = d;
    m_pal[a] = d;
  endtask

  task automatic bank_wr(bit fg, logic [5:0] v);
    @(negedge clk_i);
    idle_inputs();
    bank_wdata_i = v;
    if (fg) begin fg_bank_we_i = 1; m_fg = v; end
    else    begin bg_bank_we_i = 1; m_bg = v; end
  endtask

  // monitor
  initial begin
    exp_t x;
    forever begin
      @(posedge clk_i); #1;
      if (rst_ni) begin
        if (valid_o) begin
          if (exp_q.size() == 0) check("R8 unexpected valid", 32'(valid_o), 32'd0);
          else begin
            x = exp_q.pop_front();
            check(x.tag, 32'({red_o, grn_o, blu_o}), 32'(x.rgb));
          end
        end else if ({red_o, grn_o, blu_o} != 12'h000)
          check("R10 idle dark", 32'({red_o, grn_o, blu_o}), 32'd0);
      end
    end
  end

  // watchdog
  initial begin
    #(5 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] t;
    logic [23:0] rw;
    repeat (3) @(negedge clk_i);
    check("R11 valid after reset", 32'(valid_o), 32'd0);
    check("R11 rgb after reset", 32'({red_o, grn_o, blu_o}), 32'd0);
    rst_ni = 1;

    for (int i = 0; i < 1024; i++) begin
      t = 32'(i) * 32'h9E3779B1;
      pal_wr(10'(i), t[31:16]);
    end

    // R11: banks reset to 0, serializer empty -> tile pixel with bank 0
    cyc(0, 24'h0, 1, 4'h9, 0, "R11 empty serializer, bank 0");
    cyc(1, 24'h700000, 1, 4'h0, 0, "R11 fg bank 0");

    bank_wr(1, 6'h2A);
    bank_wr(0, 6'h15);

    // R1 nibble order, R2 exhaustion
    cyc(1, 24'h123456, 1, 4'h3, 0, "R1 nibble 5");
    cyc(0, 24'hFFFFFF, 1, 4'h3, 0, "R1 nibble 4");
    cyc(0, 24'h0, 1, 4'h3, 0, "R1 nibble 3");
    cyc(0, 24'h0, 1, 4'h3, 0, "R1 nibble 2");
    cyc(0, 24'h0, 1, 4'h3, 0, "R1 nibble 1");
    cyc(0, 24'h0, 1, 4'h3, 0, "R1 nibble 0");
    cyc(0, 24'h0, 1, 4'hC, 0, "R2 exhausted shows tile");
    cyc(0, 24'h0, 1, 4'hD, 0, "R2 exhausted shows tile");

    // R3/R4 transparency and bank selection
    cyc(1, 24'h0A0B00, 1, 4'h1, 0, "R3 zero -> tile");
    cyc(0, 24'h0, 1, 4'h2, 0, "R4 fg bank index");
    cyc(0, 24'h0, 1, 4'h4, 0, "R3 zero -> tile");
    cyc(0, 24'h0, 1, 4'h5, 0, "R4 fg bank index");
    cyc(0, 24'h0, 1, 4'h6, 0, "R3 zero -> tile");
    cyc(0, 24'h0, 1, 4'h0, 0, "R3 zero tile zero");

    // R2 load without step, gaps, mid-word reload
    cyc(1, 24'hABCDEF, 0, 4'h0, 0, "");
    cyc(0, 24'h0, 0, 4'h0, 0, "");
    cyc(0, 24'h0, 1, 4'h0, 0, "R2 stored word first nibble");
    cyc(0, 24'h0, 0, 4'h0, 0, "");
    cyc(0, 24'h0, 1, 4'h0, 0, "R2 hold across gap");
    cyc(1, 24'h98765F, 1, 4'h0, 0, "R2 reload mid-word");
    cyc(0, 24'h0, 1, 4'h0, 0, "R2 after reload");

    // R5 bank change applies to later pixels
    bank_wr(1, 6'h3F);
    cyc(1, 24'h500000, 1, 4'h0, 0, "R5 new fg bank");
    bank_wr(0, 6'h01);
    cyc(0, 24'h0, 1, 4'h8, 0, "R5 new bg bank");

    // R6/R7 palette overwrite and scaling corners
    pal_wr({6'h3F, 4'h1}, 16'hF0F0);
    pal_wr({6'h3F, 4'h2}, 16'hF8C7);
    pal_wr({6'h3F, 4'h3}, 16'hFFFF);
    pal_wr({6'h3F, 4'h4}, 16'h000F);
    cyc(1, 24'h123400, 1, 4'h0, 0, "R7 intensity 0");
    cyc(0, 24'h0, 1, 4'h0, 0, "R7 intensity 7");
    cyc(0, 24'h0, 1, 4'h0, 0, "R7 full scale");
    cyc(0, 24'h0, 1, 4'h0, 0, "R6 black entry");
    pal_wr({6'h3F, 4'h2}, 16'h9A6B);
    cyc(1, 24'h200000, 1, 4'h0, 0, "R6 overwritten entry");

    // R9 blanking
    cyc(1, 24'h333333, 1, 4'h0, 1, "R9 blank");
    cyc(0, 24'h0, 1, 4'h0, 0, "R9 unblanked");
    cyc(0, 24'h0, 1, 4'h0, 1, "R9 blank");

    // R8 isolated pixel
    cyc(0, 24'h0, 0, 4'h0, 0, "");
    cyc(0, 24'h0, 1, 4'h0, 0, "R8 isolated pixel");
    repeat (4) cyc(0, 24'h0, 0, 4'h0, 0, "");

    // streaming mix
    bank_wr(1, 6'h0B);
    bank_wr(0, 6'h2C);
    for (int n = 0; n < 600; n++) begin
      t  = $urandom;
      rw = $urandom;
      cyc((n % 6 == 0) || (t[3:0] == 4'h0), rw & {6{t[8]|t[9], 3'b111}},
          t[4] | t[5], t[15:12], t[16] & t[17] & t[18], "R1 R3 R4 R8 stream");
    end
    repeat (4) cyc(0, 24'h0, 0, 4'h0, 0, "");
    check("R8 all pixels delivered", 32'(exp_q.size()), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule